// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block turns a fast system clock, together with one of two source tick enables, into a display pixel clock. Each source tick stands for one edge of the chosen input clock, seen in the fast domain. A divide value with four fractional bits sets the length of each output period, counted in source ticks. An accumulator carries the fractional remainder from one period to the next, so over many periods the average period equals the programmed ratio exactly.

Inside each period the output waveform rises and falls at positions that are programmed separately, in half-tick units. The block produces two outputs: a one-cycle strobe on the first tick of every period, and a level waveform whose polarity can be inverted. A small write-only register port selects the source, sets the polarity, enables the divider and loads the divide and edge values.

Divide and edge values are held in shadow registers and take effect only at the next period boundary. The source select is a static choice: it is captured only while the divider is disabled.

Top module: `pix_frac_div`

## Requirements
- R1: After synchronous reset, pix_stb and pix_clk are 0, the divider is disabled, the source is the internal tick, and the divide register holds 0x10 (divide-by-one).
- R2: The divide register (address 1, bits 11:0) has 4 fractional bits. Each period lasts floor((D + r) / 16) selected ticks, where r is the 4-bit remainder carried from the previous period (0 after enable), and the new remainder is (D + r) mod 16. Any 16 consecutive periods from enable therefore total D ticks.
- R3: pix_stb is high for exactly one fast-clock cycle, on the first selected tick of each period. The first selected tick after enable starts a period.
- R4: A divide value below 0x10 behaves as 0x10, so every selected tick starts a period.
- R5: The edge register (address 2) holds the rise position in bits 8:0 and the fall position in bits 24:16, both in half-tick units. On tick k of a period (k counted from 0) the uninverted level is high when 2k >= rise and 2k < fall. A fall value equal to D >> 4 with rise 0 gives a 50% duty cycle when D/16 is even.
- R6: Control bit 17 (address 0) inverts pix_clk from the cycle after the write. While disabled, pix_clk equals that bit.
- R7: Control bit 20 selects tick_ext instead of tick_int. The select is taken from control writes made while the divider is disabled, including the write that enables it. A select change written while enabled has no effect.
- R8: Writes to the divide or edge register during a period leave that period unchanged and apply from the next period start.
- R9: Control bit 0 enables the divider. While it is clear, no strobe is produced and the count and the fractional remainder are cleared.
- R10: Writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; all logic is clocked by it |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 divide, 2 edges |
| wr_data | input | 32 | Register write data |
| tick_int | input | 1 | Tick enable of the internal bus clock source |
| tick_ext | input | 1 | Tick enable of the external display clock source |
| pix_stb | output | 1 | One-cycle strobe at each output period start |
| pix_clk | output | 1 | Pixel clock waveform after polarity |

## Verification
On every cycle the assertions check the following: the count stays below the current period length; a period never has zero length; a strobe always follows an enabled tick; the shadowed edges and the applied source hold between the points where they may change; and a disabled divider stays silent. The average period, the alternating lengths a fractional ratio produces, the duty cycle for given edges, the deferral of mid-period writes and the polarity change can only be shown by the bench's scenarios. Each scenario measures the distances between strobes and counts the high cycles within each period against a behavioural model.

// File: rtl/pix_frac_div_pkg.sv
package pix_frac_div_pkg;

    localparam int DIV_W     = 12;
    localparam int FRAC_W    = 4;
    localparam int EDGE_W    = 9;
    localparam int LEN_W     = DIV_W - FRAC_W + 1;
    localparam int SUM_W     = DIV_W + 1;
    localparam int ADDR_W    = 2;
    localparam int DATA_W    = 32;

    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1 << FRAC_W);

    localparam int BIT_EN    = 0;
    localparam int BIT_INV   = 17;
    localparam int BIT_EXT   = 20;
    localparam int RISE_LSB  = 0;
    localparam int FALL_LSB  = 16;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_DIV  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_EDGE = 2'd2;

    typedef struct packed {
        logic en;
        logic inv;
        logic ext;
    } ctrl_t;

    typedef struct packed {
        logic [EDGE_W-1:0] fall;
        logic [EDGE_W-1:0] rise;
    } edge_t;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
        return (d < DIV_ONE) ? DIV_ONE : d;
    endfunction

    function automatic logic level_at(input logic [LEN_W-1:0] k, input edge_t e);
        logic [LEN_W:0] half;
        half = {k, 1'b0};
        return (half >= (LEN_W+1)'(e.rise)) && (half < (LEN_W+1)'(e.fall));
    endfunction

endpackage

// File: rtl/pix_frac_div_regs.sv
module pix_frac_div_regs
    import pix_frac_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output ctrl_t             ctrl_d,
    output logic [DIV_W-1:0]  div_q,
    output edge_t             edge_q
);

    logic [DIV_W-1:0] div_d;
    edge_t            edge_d;

    always_comb begin
        ctrl_d = ctrl_q;
        div_d  = div_q;
        edge_d = edge_q;
        if (wr_en) begin
            case (wr_addr)
                ADR_CTRL: begin
                    ctrl_d.en  = wr_data[BIT_EN];
                    ctrl_d.inv = wr_data[BIT_INV];
                    ctrl_d.ext = wr_data[BIT_EXT];
                end
                ADR_DIV:  div_d = wr_data[DIV_W-1:0];
                ADR_EDGE: begin
                    edge_d.rise = wr_data[RISE_LSB +: EDGE_W];
                    edge_d.fall = wr_data[FALL_LSB +: EDGE_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= DIV_ONE;
            edge_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            div_q  <= div_d;
            edge_q <= edge_d;
        end
    end

    // R10: without a write, nothing in the register file moves
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(ctrl_q) && $stable(div_q) && $stable(edge_q)));

endmodule

// File: rtl/pix_frac_div_src.sv
module pix_frac_div_src
    import pix_frac_div_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ext_next,
    input  logic tick_int,
    input  logic tick_ext,
    output logic tick
);

    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= 1'b0;
        else if (!en)
            sel_q <= ext_next;
    end

    assign tick = sel_q ? tick_ext : tick_int;

    // R7: while enabled the applied source cannot change
    a_r7_src_frozen: assert property (@(posedge clk) disable iff (rst)
        en |=> $stable(sel_q));

endmodule

// File: rtl/pix_frac_div_phase.sv
module pix_frac_div_phase
    import pix_frac_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [DIV_W-1:0] div,
    input  edge_t            edges,
    output logic             stb,
    output logic             lvl
);

    logic [LEN_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  len_q;
    logic [FRAC_W-1:0] frac_q;
    edge_t             edge_sh;
    logic              last;
    logic              load;
    logic [SUM_W-1:0]  sum;
    logic [LEN_W-1:0]  cnt_inc;

    assign last    = (cnt_q == len_q - LEN_W'(1));
    assign load    = en && tick && last;
    assign sum     = SUM_W'(clamp_div(div)) + SUM_W'(frac_q);
    assign cnt_inc = cnt_q + LEN_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            len_q   <= LEN_W'(1);
            frac_q  <= '0;
            edge_sh <= '0;
            stb     <= 1'b0;
            lvl     <= 1'b0;
        end else if (!en) begin
            cnt_q  <= '0;
            len_q  <= LEN_W'(1);
            frac_q <= '0;
            stb    <= 1'b0;
            lvl    <= 1'b0;
        end else if (tick) begin
            if (last) begin
                cnt_q   <= '0;
                len_q   <= sum[SUM_W-1:FRAC_W];
                frac_q  <= sum[FRAC_W-1:0];
                edge_sh <= edges;
                stb     <= 1'b1;
                lvl     <= level_at('0, edges);
            end else begin
                cnt_q <= cnt_inc;
                stb   <= 1'b0;
                lvl   <= level_at(cnt_inc, edge_sh);
            end
        end else begin
            stb <= 1'b0;
        end
    end

    // R2: the position never leaves the current period
    a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (rst)
        cnt_q < len_q);

    // R4: a period never has zero length
    a_r4_len_nonzero: assert property (@(posedge clk) disable iff (rst)
        len_q != '0);

    // R3: a strobe only follows an enabled tick
    a_r3_stb_after_tick: assert property (@(posedge clk) disable iff (rst)
        stb |-> $past(en && tick));

    // R8: edge shadow only changes at a period start
    a_r8_edges_held: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(edge_sh));

    // R9: disabled means silent and cleared
    a_r9_quiet_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!stb && cnt_q == '0 && frac_q == '0));

endmodule

// File: rtl/pix_frac_div.sv
module pix_frac_div
    import pix_frac_div_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        tick_int,
    input  logic        tick_ext,
    output logic        pix_stb,
    output logic        pix_clk
);

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_d;
    logic [DIV_W-1:0] div_q;
    edge_t            edge_q;
    logic             tick;
    logic             lvl;

    pix_frac_div_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .ctrl_d  (ctrl_d),
        .div_q   (div_q),
        .edge_q  (edge_q)
    );

    pix_frac_div_src i_src (
        .clk      (clk),
        .rst      (rst),
        .en       (ctrl_q.en),
        .ext_next (ctrl_d.ext),
        .tick_int (tick_int),
        .tick_ext (tick_ext),
        .tick     (tick)
    );

    pix_frac_div_phase i_phase (
        .clk   (clk),
        .rst   (rst),
        .en    (ctrl_q.en),
        .tick  (tick),
        .div   (div_q),
        .edges (edge_q),
        .stb   (pix_stb),
        .lvl   (lvl)
    );

    assign pix_clk = lvl ^ ctrl_q.inv;

    // R6: once disabled for a cycle, the output rests at the polarity bit
    a_r6_rest_level: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && $past(!ctrl_q.en)) |-> (pix_clk == ctrl_q.inv));

endmodule

// File: tb/test_pix_frac_div.sv
module test_pix_frac_div;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tick_int = 1'b0;
    logic        tick_ext = 1'b0;
    logic        pix_stb;
    logic        pix_clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int int_every = 1;
    int ext_every = 3;

    // behavioural reference state
    int m_en = 0, m_inv = 0, m_ext = 0, m_sel = 0;
    int m_div = 16, m_rise = 0, m_fall = 0;
    int m_cnt = 0, m_len = 1, m_frac = 0, m_srise = 0, m_sfall = 0;
    int m_stb = 0, m_lvl = 0;
    bit model_on = 0;

    int stb_t[$];
    int stb_hi[$];
    int hi_total = 0;

    always #2.5 clk = ~clk;

    pix_frac_div i_pix_frac_div (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tick_int (tick_int),
        .tick_ext (tick_ext),
        .pix_stb  (pix_stb),
        .pix_clk  (pix_clk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lvl_of(input int k, input int r, input int f);
        return ((2 * k >= r) && (2 * k < f)) ? 1 : 0;
    endfunction

    always @(negedge clk) begin
        tick_int <= (cyc % int_every) == 0;
        tick_ext <= (cyc % ext_every) == 0;
    end

    always @(posedge clk) begin
        int tk, d, s, en_old;
        cyc++;
        if (rst) begin
            m_en = 0; m_inv = 0; m_ext = 0; m_sel = 0;
            m_div = 16; m_rise = 0; m_fall = 0;
            m_cnt = 0; m_len = 1; m_frac = 0; m_srise = 0; m_sfall = 0;
            m_stb = 0; m_lvl = 0;
        end else begin
            en_old = m_en;
            tk = m_sel ? tick_ext : tick_int;
            if (!m_en) begin
                m_cnt = 0; m_len = 1; m_frac = 0; m_stb = 0; m_lvl = 0;
            end else if (tk) begin
                if (m_cnt == m_len - 1) begin
                    d = (m_div < 16) ? 16 : m_div;
                    s = d + m_frac;
                    m_len = s / 16;
                    m_frac = s % 16;
                    m_cnt = 0;
                    m_srise = m_rise;
                    m_sfall = m_fall;
                    m_stb = 1;
                end else begin
                    m_cnt++;
                    m_stb = 0;
                end
                m_lvl = lvl_of(m_cnt, m_srise, m_sfall);
            end else begin
                m_stb = 0;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin
                        m_en = wr_data[0]; m_inv = wr_data[17]; m_ext = wr_data[20];
                    end
                    2'd1: m_div = wr_data[11:0];
                    2'd2: begin
                        m_rise = wr_data[8:0]; m_fall = wr_data[24:16];
                    end
                    default: ;
                endcase
            end
            if (!en_old) m_sel = m_ext;
        end
        #1;
        if (model_on) begin
            chk(pix_stb === m_stb[0], "R3", pix_stb, m_stb);
            chk(pix_clk === (m_lvl[0] ^ m_inv[0]), "R5", pix_clk, m_lvl ^ m_inv);
        end
        if (pix_stb === 1'b1) begin
            stb_t.push_back(cyc);
            stb_hi.push_back(hi_total);
        end
        if (pix_clk === 1'b1) hi_total++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic grab(input int n);
        stb_t.delete();
        stb_hi.delete();
        while (stb_t.size() < n) @(negedge clk);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        idle(1);
        // R1: reset state
        chk(pix_stb == 1'b0, "R1", pix_stb, 0);
        chk(pix_clk == 1'b0, "R1", pix_clk, 0);
        model_on = 1;

        // R10: address 3 writes ignored (polarity bit would show on pix_clk)
        wr(3, 32'hFFFF_FFFF);
        idle(2);
        chk(pix_clk == 1'b0, "R10", pix_clk, 0);
        chk(stb_t.size() == 0, "R10", stb_t.size(), 0);

        // R1: default divide is one: every tick is a period
        wr(0, 1);
        grab(4);
        chk(stb_t[3] - stb_t[0] == 3, "R1", stb_t[3] - stb_t[0], 3);

        // R2: fractional ratio 2.5
        wr(0, 0);
        wr(1, 32'h28);
        wr(0, 1);
        grab(17);
        chk(stb_t[1] - stb_t[0] == 2, "R2", stb_t[1] - stb_t[0], 2);
        chk(stb_t[2] - stb_t[1] == 3, "R2", stb_t[2] - stb_t[1], 3);
        chk(stb_t[16] - stb_t[0] == 40, "R2", stb_t[16] - stb_t[0], 40);
        // R3: strobes never adjacent at a ratio of 2.5
        chk(stb_t[1] - stb_t[0] > 1, "R3", stb_t[1] - stb_t[0], 2);

        // R4: divide below one clamps
        wr(0, 0);
        wr(1, 32'h05);
        wr(0, 1);
        grab(5);
        for (int i = 1; i < 5; i++)
            chk(stb_t[i] - stb_t[i-1] == 1, "R4", stb_t[i] - stb_t[i-1], 1);

        // R5: 50% duty with ratio 4
        wr(0, 0);
        wr(1, 32'h40);
        wr(2, 4 << 16);
        wr(0, 1);
        grab(4);
        chk(stb_hi[2] - stb_hi[1] == 2, "R5", stb_hi[2] - stb_hi[1], 2);
        // R5: half-tick rise 1, fall 9: high on ticks 1..3
        wr(2, (9 << 16) | 1);
        grab(4);
        chk(stb_hi[3] - stb_hi[2] == 3, "R5", stb_hi[3] - stb_hi[2], 3);

        // R6: inversion while running
        wr(0, 1 | (1 << 17));
        grab(4);
        chk(stb_hi[3] - stb_hi[2] == 1, "R6", stb_hi[3] - stb_hi[2], 1);
        wr(0, 1 << 17);
        idle(3);
        chk(pix_clk == 1'b1, "R6", pix_clk, 1);

        // R8: mid-period divide write is deferred
        wr(1, 32'h80);
        wr(2, 8 << 16);
        wr(0, 1);
        grab(1);
        idle(2);
        wr(1, 32'h30);
        grab(3);
        chk(stb_t[1] - stb_t[0] == 8 || stb_t[1] - stb_t[0] == 3, "R8",
            stb_t[1] - stb_t[0], 8);
        chk(stb_t[2] - stb_t[1] == 3, "R8", stb_t[2] - stb_t[1], 3);

        // R9: disabled is silent
        wr(0, 0);
        stb_t.delete();
        idle(12);
        chk(stb_t.size() == 0, "R9", stb_t.size(), 0);
        chk(pix_clk == 1'b0, "R9", pix_clk, 0);

        // R7: external source, select frozen while enabled
        wr(0, 1 << 20);
        wr(1, 32'h20);
        wr(0, 1 | (1 << 20));
        grab(3);
        chk(stb_t[2] - stb_t[1] == 6, "R7", stb_t[2] - stb_t[1], 6);
        wr(0, 1);
        grab(3);
        chk(stb_t[2] - stb_t[1] == 6, "R7", stb_t[2] - stb_t[1], 6);

        idle(4);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule